// File: doc/BRIEF.md
# Per-Channel Selectable Debounce Filter

This block sits between a bank of raw interrupt lines and the interrupt detector. The lowest `DB_CNT` lines each own a small filter. When a filter is active, the line's output follows the raw input only after the input has stayed at its new value for a chosen number of timebase ticks. Any return to the old value before that restarts the wait. A line whose filter is off, or whose channel is configured for edge sensitivity, passes straight through in the same cycle. Lines at or above `DB_CNT` always pass through.

Each filtered channel has an 8-bit control field. Four fields are packed into each 32-bit control word: channel k sits in word k/4, at bits 8*(k mod 4) and up. Software reaches the words by word index, which corresponds to a byte offset of 4 times the index. There are three accesses:
- a set write, which ORs bits into the field;
- a clear write, which removes the written bits from the field;
- a read, which is combinational.

A write to a field bit that restarts the count takes effect on the same clock edge and is never stored. One shared prescaler produces a tick every `TICK_DIV` system clocks. With the default value, one tick lasts 0.5 ms at 50 MHz.

The block has no streaming data path. Every pin is a plain control or status level, writes are accepted in every cycle, and there is no back-pressure.

Top module: `db_filter_bank`

## Requirements
- R1: After reset, every control field reads 0 and every filt_out bit equals its raw_in bit.
- R2: Field bit 0 is the enable and bits 6:4 are the interval code. Channel k uses bits 8*(k mod 4)+7 : 8*(k mod 4) of word k/4. With cfg_op=0 (set), written ones are ORed into the stored bits 0 and 6:4. With cfg_op=1 (clear), written ones clear those stored bits. Bits 1, 2, 3 and 7 of every field read 0.
- R3: A clear write of 0xFF to a field wipes the whole field, and field bit 1 always reads back 0.
- R4: While a channel's enable is 0, filt_out equals raw_in combinationally.
- R5: An active channel (enable=1, lvl_mode=1) changes its output to the raw value on the tick on which the raw input has differed from the output for N consecutive ticks. N is 1, 2, 32, 64, 128, 256, 512 or 1024 for codes 0 through 7. A tick occurs every TICK_DIV clocks, counted from reset.
- R6: On an active channel, any clock in which the raw input equals the held output zeroes the count, so a bounce restarts the interval.
- R7: A channel with lvl_mode=0 passes raw_in straight through, whatever its enable bit.
- R8: Channels with an index of DB_CNT or higher have no filter: their output equals their input, and their field bits read 0.
- R9: A set write with field bit 1 high zeroes that channel's count on the same edge. The output is held and the stored field is unchanged.
- R10: A svc_hit pulse on an active channel zeroes its count on that edge, and the output is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_op | input | 1 | 0 = set write, 1 = clear write |
| cfg_word | input | WW | Word index of the write |
| cfg_wdata | input | 32 | Write data, four packed fields |
| cfg_raddr | input | WW | Word index of the read |
| cfg_rdata | output | 32 | Read data of word cfg_raddr |
| lvl_mode | input | DB_CNT | 1 = channel is level sensitive |
| svc_hit | input | DB_CNT | One-cycle pulse when a channel's interrupt is serviced |
| raw_in | input | NCH | Unfiltered interrupt lines |
| filt_out | output | NCH | Filtered lines to the detector |

## Verification
The filter is driven with four kinds of input: single clean steps, a long hold on the largest code, dense bounce with gaps shorter than the interval, and steps interrupted by restart writes or service pulses. A clean step shows that the interval is counted in ticks from the first differing cycle. Bounce shows whether an early return resets the count or only pauses it. The restart cases separate a zeroed count from a held output. Disabled, edge-mode and unfiltered channels toggle alongside, which shows that they bypass the filter without delay.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 11;
  localparam logic [7:0] FIELD_KEEP = 8'h71;
  localparam logic OP_SET = 1'b0;
  localparam logic OP_CLR = 1'b1;

  // interval code -> number of ticks the input must stay stable
  function automatic logic [CNT_W-1:0] sel_ticks(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    sel_ticks = CNT_W'(1);
      3'd1:    sel_ticks = CNT_W'(2);
      default: sel_ticks = CNT_W'(1) << (32'(s) + 3);
    endcase
  endfunction
endpackage

// File: rtl/db_tick_gen.sv
module db_tick_gen #(
  parameter int TICK_DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pc;

  assign tick = (pc == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + PW'(1);
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R5
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/db_ctrl_regs.sv
module db_ctrl_regs
  import db_pkg::*;
#(
  parameter int DB_CNT = 6,
  parameter int NW     = 2,
  parameter int WW     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    op,
  input  logic [WW-1:0]           word,
  input  logic [31:0]             wdata,
  input  logic [WW-1:0]           raddr,
  output logic [31:0]             rdata,
  output logic [DB_CNT-1:0]       en,
  output logic [DB_CNT*SEL_W-1:0] sel,
  output logic [DB_CNT-1:0]       rst_hit
);
  logic [31:0] w_q [NW];

  function automatic logic [31:0] keep_mask(input int w);
    logic [31:0] m;
    m = '0;
    for (int f = 0; f < 4; f++)
      if (w * 4 + f < DB_CNT) m[8*f +: 8] = FIELD_KEEP;
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) w_q[w] <= '0;
    end else if (wr) begin
      for (int w = 0; w < NW; w++) begin
        if (32'(word) == w) begin
          if (op == OP_CLR) w_q[w] <= w_q[w] & ~(wdata & keep_mask(w));
          else              w_q[w] <= w_q[w] | (wdata & keep_mask(w));
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++)
      if (32'(raddr) == w) rdata = w_q[w];
  end

  genvar ch;
  generate
    for (ch = 0; ch < DB_CNT; ch++) begin : g_field
      localparam int WI = ch / 4;
      localparam int BO = 8 * (ch % 4);
      assign en[ch] = w_q[WI][BO];
      assign sel[SEL_W*ch +: SEL_W] = w_q[WI][BO+4 +: SEL_W];
      assign rst_hit[ch] = wr && (op == OP_SET) && (32'(word) == WI) && wdata[BO+1];
    end
  endgenerate

  // R3
  field_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && op == OP_CLR && word == '0 && wdata[7:0] == 8'hFF) |=> (w_q[0][7:0] == 8'h00));
endmodule

// File: rtl/db_chan_filter.sv
module db_chan_filter
  import db_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             act,
  input  logic             restart,
  input  logic             raw,
  input  logic [SEL_W-1:0] sel,
  output logic             out
);
  logic             q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   nxt;

  assign lim = sel_ticks(sel);
  assign nxt = {1'b0, cnt} + (CNT_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!act) begin
      q   <= raw;
      cnt <= '0;
    end else if (restart || raw == q) begin
      cnt <= '0;
    end else if (tick) begin
      if (nxt >= {1'b0, lim}) begin
        q   <= raw;
        cnt <= '0;
      end else begin
        cnt <= nxt[CNT_W-1:0];
      end
    end
  end

  assign out = act ? q : raw;

  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tick) |=> $stable(q));
  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && restart) |=> (cnt == '0 && $stable(q)));
  // R6
  bounce_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && raw == q) |=> (cnt == '0));
endmodule

// File: rtl/db_filter_bank.sv
module db_filter_bank
  import db_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DB_CNT   = 6,
  parameter int TICK_DIV = 25000,
  localparam int NW = (DB_CNT + 3) / 4,
  localparam int WW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_op,
  input  logic [WW-1:0]     cfg_word,
  input  logic [31:0]       cfg_wdata,
  input  logic [WW-1:0]     cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic [DB_CNT-1:0] lvl_mode,
  input  logic [DB_CNT-1:0] svc_hit,
  input  logic [NCH-1:0]    raw_in,
  output logic [NCH-1:0]    filt_out
);
  logic                    tick;
  logic [DB_CNT-1:0]       en;
  logic [DB_CNT*SEL_W-1:0] sel;
  logic [DB_CNT-1:0]       rst_hit;

  db_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  db_ctrl_regs #(.DB_CNT(DB_CNT), .NW(NW), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .op(cfg_op), .word(cfg_word),
    .wdata(cfg_wdata), .raddr(cfg_raddr), .rdata(cfg_rdata),
    .en(en), .sel(sel), .rst_hit(rst_hit)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      if (ch < DB_CNT) begin : g_filt
        logic act;
        assign act = en[ch] & lvl_mode[ch];
        db_chan_filter u_filt (
          .clk(clk), .rst_n(rst_n), .tick(tick), .act(act),
          .restart(rst_hit[ch] | svc_hit[ch]), .raw(raw_in[ch]),
          .sel(sel[SEL_W*ch +: SEL_W]), .out(filt_out[ch])
        );
        // R7
        edge_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !lvl_mode[ch] |-> (filt_out[ch] == raw_in[ch]));
      end else begin : g_pass
        assign filt_out[ch] = raw_in[ch];
      end
    end
  endgenerate
endmodule

// File: tb/db_filter_bank_test.sv
module db_filter_bank_test;
  localparam int NCH = 8;
  localparam int DB  = 6;
  localparam int TD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_op = 1'b0;
  logic [0:0]  cfg_word = '0, cfg_raddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [DB-1:0]  lvl_mode = '0, svc_hit = '0;
  logic [NCH-1:0] raw_in = '0;
  logic [NCH-1:0] filt_out;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  int m_en[DB], m_sel[DB], m_cnt[DB], m_pc;
  logic m_q[DB];

  always #10 clk = ~clk;

  db_filter_bank #(.NCH(NCH), .DB_CNT(DB), .TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .lvl_mode(lvl_mode), .svc_hit(svc_hit),
    .raw_in(raw_in), .filt_out(filt_out)
  );

  function automatic int ticks_for(int code);
    int t [8] = '{1, 2, 32, 64, 128, 256, 512, 1024};
    return t[code];
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0;
      for (int c = 0; c < DB; c++) begin
        m_en[c] = 0; m_sel[c] = 0; m_cnt[c] = 0; m_q[c] = 1'b0;
      end
    end else begin
      bit tk;
      tk = (m_pc == TD - 1);
      for (int c = 0; c < DB; c++) begin
        bit a, rs;
        a  = (m_en[c] == 1) && lvl_mode[c];
        rs = (cfg_wr && !cfg_op && int'(cfg_word) == c / 4 && cfg_wdata[8*(c%4)+1]) || svc_hit[c];
        if (!a) begin m_q[c] = raw_in[c]; m_cnt[c] = 0; end
        else if (rs || raw_in[c] == m_q[c]) m_cnt[c] = 0;
        else if (tk) begin
          if (m_cnt[c] + 1 >= ticks_for(m_sel[c])) begin m_q[c] = raw_in[c]; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end
      end
      if (cfg_wr) begin
        for (int c = 0; c < DB; c++) begin
          if (int'(cfg_word) == c / 4) begin
            logic [7:0] b;
            b = cfg_wdata[8*(c%4) +: 8];
            if (!cfg_op) begin
              if (b[0]) m_en[c] = 1;
              m_sel[c] = m_sel[c] | int'(b[6:4]);
            end else begin
              if (b[0]) m_en[c] = 0;
              m_sel[c] = m_sel[c] & ~int'(b[6:4]);
            end
          end
        end
      end
      m_pc = tk ? 0 : m_pc + 1;
    end
  end

  // compare late in every cycle
  always @(posedge clk) begin
    logic [NCH-1:0] eo;
    logic [31:0] er;
    #15;
    cycles++;
    eo = raw_in;
    for (int c = 0; c < DB; c++)
      if (m_en[c] == 1 && lvl_mode[c]) eo[c] = m_q[c];
    er = '0;
    for (int c = 0; c < DB; c++)
      if (int'(cfg_raddr) == c / 4)
        er[8*(c%4) +: 8] = {1'b0, 3'(m_sel[c]), 3'b000, 1'(m_en[c])};
    checks += 2;
    if (filt_out !== eo) begin
      errors++;
      $display("FAIL %s filt_out actual=%b expected=%b at cycle %0d", phase, filt_out, eo, cycles);
    end
    if (cfg_rdata !== er) begin
      errors++;
      $display("FAIL %s cfg_rdata actual=%h expected=%h at cycle %0d", phase, cfg_rdata, er, cycles);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic op, logic [0:0] w, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_op = op; cfg_word = w; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state on both words
    phase = "R1"; idle(3); cfg_raddr = 1'b1; idle(3); cfg_raddr = 1'b0;
    // R4: disabled channel passes through
    phase = "R4";
    for (int i = 0; i < 6; i++) begin raw_in[0] = ~raw_in[0]; idle(2); end
    // R2: program ch0 code0, ch1 code2, ch2 code7, ch3 code0 (edge mode)
    phase = "R2";
    lvl_mode = 6'b000111;
    cfg_write(1'b0, 1'b0, 32'h01712101);
    idle(4);
    // R5: clean steps
    phase = "R5";
    raw_in[0] = 1'b1; idle(12);
    raw_in[1] = 1'b1; idle(200);
    raw_in[2] = 1'b1; idle(4200);
    raw_in[2] = 1'b0; idle(4200);
    // R6: bounce on ch1 shorter than its interval
    phase = "R6";
    raw_in[1] = 1'b0;
    for (int i = 0; i < 20; i++) begin idle(1 + ($urandom % 60)); raw_in[1] = ~raw_in[1]; end
    raw_in[1] = 1'b1; idle(200);
    for (int i = 0; i < 30; i++) begin idle(1 + ($urandom % 3)); raw_in[0] = ~raw_in[0]; end
    idle(20);
    // R7: ch3 enabled but edge-sensitive
    phase = "R7";
    for (int i = 0; i < 8; i++) begin raw_in[3] = ~raw_in[3]; idle(3); end
    // R8: word 1 holds ch4, ch5 only; ch6, ch7 unfiltered
    phase = "R8";
    cfg_raddr = 1'b1;
    lvl_mode[5:4] = 2'b11;
    cfg_write(1'b0, 1'b1, 32'hFFFFFFFF);
    for (int i = 0; i < 8; i++) begin raw_in[7:4] = raw_in[7:4] ^ 4'b1111; idle(5); end
    cfg_write(1'b1, 1'b1, 32'h000000FF);
    idle(5);
    cfg_raddr = 1'b0;
    // R9: restart bit mid-interval on ch1
    phase = "R9";
    raw_in[1] = 1'b0; idle(80);
    cfg_write(1'b0, 1'b0, 32'h00000200);
    idle(100);
    idle(60);
    // R10: service pulse mid-interval on ch1
    phase = "R10";
    raw_in[1] = 1'b1; idle(80);
    svc_hit[1] = 1'b1; idle(1); svc_hit[1] = 1'b0;
    idle(160);
    // R3: clear 0xFF wipes ch1 field; restart bit never read back
    phase = "R3";
    cfg_write(1'b0, 1'b0, 32'h00000202);
    idle(3);
    cfg_write(1'b1, 1'b0, 32'h0000FF00);
    idle(3);
    raw_in[1] = 1'b0; idle(4);
    finish_run();
  end
endmodule